// File: doc/BRIEF.md
# Bank Chip-Select Decoder with Selectable Address Decoding

This block turns a processor-style bus request (24-bit byte address, 8-bit data, a read/write direction bit and a request valid) into active-low chip selects for four 4 KiB byte-wide banks. It also serves the access from small banks modelled inside the block. A build-time parameter picks one of three decoding schemes:

- **Full decoding**: every upper address bit is compared, so each byte has exactly one address.
- **Partial decoding**: only the top address bit is used, so each bank answers at many aliased addresses.
- **Mixed decoding**: the lower half of the space is fully decoded and the upper half is partially decoded.

The chip selects are combinational from the current request. A request that lands in unpopulated space selects nothing. It is answered one cycle later with an error flag instead of data.

Each modelled bank keeps the low `STORE_AW` offset bits of A11..A0. The default is 8, which gives 256 bytes per bank. Setting `STORE_AW` to 12 gives the full 4 KiB. The bench uses only offsets below 0x100.

Top module: `mem_bank_decoder`

## Requirements
- R1: Full mode: cs_n[0] is low only for addresses 0x000000–0x000FFF and cs_n[1] only for 0x001000–0x001FFF; every other address selects no bank and is answered with bus_err.
- R2: Partial mode: address bit 23 alone picks the bank (0 gives cs_n[0], 1 gives cs_n[1]); every address that shares the offset bits reaches the same byte, and bus_err is never raised.
- R3: Mixed mode with bit 23 clear: bits 21..12 must be zero, and bit 22 picks cs_n[0] (0x000000–0x000FFF) or cs_n[1] (0x400000–0x400FFF); any other address below 0x800000 selects nothing and raises bus_err.
- R4: Mixed mode with bit 23 set: bit 12 picks cs_n[2] (0) or cs_n[3] (1); bits 22..13 have no effect, so each bank aliases across 0x800000–0xFFFFFF.
- R5: At most one chip select is low in any cycle; with req_vld low all of cs_n is high, and one cycle later ack and bus_err are both low.
- R6: rd_wr_n = 0 writes wdata into the selected bank at the clock edge, and rd_wr_n = 1 reads it. Every valid request is answered one cycle later with a single-cycle ack, and a read presents the byte on rdata in that same cycle.
- R7: An access to unpopulated space drives no chip select and is answered with ack and bus_err high and rdata equal to 0x00.
- R8: A write to unpopulated space leaves the contents of every bank unchanged.
- R9: In full and partial mode, cs_n[2] and cs_n[3] stay high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Request valid for this cycle |
| req_addr | input | 24 | Byte address |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Write data |
| cs_n | output | 4 | Active-low bank selects, bit i for bank i |
| ack | output | 1 | Response pulse, one cycle after a request |
| bus_err | output | 1 | Response flag for an access to unpopulated space |
| rdata | output | 8 | Read data, 0x00 on error |

## Verification
The bench targets the bits that separate the three schemes.

- **Full mode**: it probes the address just past the second bank. A decoder that drops the top bits would alias there instead of raising an error.
- **Partial mode**: it writes through one alias and reads back through another far away. A design that compared more bits would return stale data or an error.
- **Mixed mode**: it sets bit 21 and bit 12 in the lower half, which must give an error. It also varies bits 22..13 in the upper half, which must be ignored. A swapped bank bit would steer those accesses to the wrong bank.

After each write to empty space, the bench reads the banks back. A decoder that let such a write through would corrupt a stored byte.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
   typedef enum logic [1:0] {
      DEC_FULL    = 2'd0,
      DEC_PARTIAL = 2'd1,
      DEC_MIXED   = 2'd2
   } dec_mode_e;
endpackage

// File: rtl/mbd_decode.sv
module mbd_decode
   import mbd_pkg::*;
#(
   parameter dec_mode_e MODE    = DEC_FULL,
   parameter int        ADDR_W  = 24,
   parameter int        BANK_AW = 12,
   parameter int        N_BANKS = 4
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [N_BANKS-1:0] sel,
   output logic               empty
);
   localparam int SW = (N_BANKS > 1) ? $clog2(N_BANKS) : 1;
   localparam int HI = ADDR_W - 1;
   localparam int SUB = ADDR_W - 2;
   localparam logic [N_BANKS-1:0] ONE = N_BANKS'(1);

   logic [SW-1:0] idx;

   generate
      if (MODE == DEC_FULL) begin : g_full
         always_comb begin
            idx   = SW'(addr[BANK_AW]);
            empty = (addr[HI:BANK_AW+1] != '0);
            sel   = empty ? '0 : (ONE << idx);
         end
      end else if (MODE == DEC_PARTIAL) begin : g_part
         always_comb begin
            idx   = SW'(addr[HI]);
            empty = 1'b0;
            sel   = ONE << idx;
         end
      end else begin : g_mixed
         always_comb begin
            if (addr[HI]) begin
               idx   = SW'({1'b1, addr[BANK_AW]});
               empty = 1'b0;
            end else begin
               idx   = SW'(addr[SUB]);
               empty = (addr[SUB-1:BANK_AW] != '0);
            end
            sel = empty ? '0 : (ONE << idx);
         end
      end
   endgenerate
endmodule

// File: rtl/mbd_bank.sv
module mbd_bank #(
   parameter int DATA_W   = 8,
   parameter int STORE_AW = 8
) (
   input  logic                clk,
   input  logic                we,
   input  logic                re,
   input  logic [STORE_AW-1:0] idx,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata
);
   localparam int DEPTH = 2 ** STORE_AW;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
      if (re) rdata <= mem[idx];
   end
endmodule

// File: rtl/mbd_resp.sv
module mbd_resp #(
   parameter int DATA_W  = 8,
   parameter int N_BANKS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_vld,
   input  logic               is_read,
   input  logic               empty,
   input  logic [N_BANKS-1:0] sel,
   input  logic [DATA_W-1:0]  bank_rd [N_BANKS],
   output logic               ack,
   output logic               bus_err,
   output logic [DATA_W-1:0]  rdata
);
   logic [N_BANKS-1:0] rsel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack     <= 1'b0;
         bus_err <= 1'b0;
         rsel_q  <= '0;
      end else begin
         ack     <= req_vld;
         bus_err <= req_vld & empty;
         rsel_q  <= (req_vld & is_read & ~empty) ? sel : '0;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_BANKS; i++)
         if (rsel_q[i]) rdata = rdata | bank_rd[i];
   end
endmodule

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder
   import mbd_pkg::*;
#(
   parameter dec_mode_e MODE     = DEC_FULL,
   parameter int        ADDR_W   = 24,
   parameter int        DATA_W   = 8,
   parameter int        BANK_AW  = 12,
   parameter int        STORE_AW = 8,
   parameter int        N_BANKS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic [23:0]       req_addr,
   input  logic              rd_wr_n,
   input  logic [7:0]        wdata,
   output logic [3:0]        cs_n,
   output logic              ack,
   output logic              bus_err,
   output logic [7:0]        rdata
);
   generate
      if (ADDR_W != 24 || DATA_W != 8 || N_BANKS != 4) begin : g_bad_shape
         $error("mem_bank_decoder: port widths fix ADDR_W=24, DATA_W=8, N_BANKS=4");
      end
      if (STORE_AW < 1 || STORE_AW > BANK_AW) begin : g_bad_store
         $error("mem_bank_decoder: STORE_AW must lie in 1..BANK_AW");
      end
      if (ADDR_W < BANK_AW + 3) begin : g_bad_addr
         $error("mem_bank_decoder: ADDR_W too small for bank offset");
      end
   endgenerate

   logic [N_BANKS-1:0] sel;
   logic               empty;
   logic               go;
   logic [N_BANKS-1:0] sel_g;
   logic [DATA_W-1:0]  bank_rd [N_BANKS];

   mbd_decode #(
      .MODE(MODE), .ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .N_BANKS(N_BANKS)
   ) i_decode (
      .addr(req_addr), .sel(sel), .empty(empty)
   );

   assign go    = req_vld & ~empty;
   assign sel_g = sel & {N_BANKS{go}};
   assign cs_n  = ~sel_g;

   generate
      for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
         mbd_bank #(.DATA_W(DATA_W), .STORE_AW(STORE_AW)) i_bank (
            .clk  (clk),
            .we   (sel_g[b] & ~rd_wr_n),
            .re   (sel_g[b] & rd_wr_n),
            .idx  (req_addr[STORE_AW-1:0]),
            .wdata(wdata),
            .rdata(bank_rd[b])
         );
      end
   endgenerate

   mbd_resp #(.DATA_W(DATA_W), .N_BANKS(N_BANKS)) i_resp (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .is_read(rd_wr_n),
      .empty(empty), .sel(sel), .bank_rd(bank_rd),
      .ack(ack), .bus_err(bus_err), .rdata(rdata)
   );
endmodule

// File: rtl/mbd_chk.sv
module mbd_chk
   import mbd_pkg::*;
#(
   parameter dec_mode_e MODE = DEC_FULL
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_vld,
   input logic [3:0] cs_n,
   input logic       ack,
   input logic       bus_err,
   input logic [7:0] rdata
);
   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n)); // R5
   AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n) !req_vld |-> (&cs_n)); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req_vld |=> (!ack && !bus_err)); // R5
   AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) req_vld |=> ack); // R6
   AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n) (req_vld && (&cs_n)) |=> bus_err); // R7
   AST_SEL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n) (req_vld && !(&cs_n)) |=> !bus_err); // R7
   AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) bus_err |-> (rdata == 8'h00)); // R7

   generate
      if (MODE != DEC_MIXED) begin : g_two_bank
         AST_UPPER_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (&cs_n[3:2])); // R9
      end
      if (MODE == DEC_PARTIAL) begin : g_part
         AST_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n) !bus_err); // R2
      end
   endgenerate
endmodule

bind mem_bank_decoder mbd_chk #(.MODE(MODE)) i_chk (
   .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .cs_n(cs_n),
   .ack(ack), .bus_err(bus_err), .rdata(rdata)
);

// File: tb/test_mem_bank_decoder.sv
`timescale 1ns/1ps
module test_mem_bank_decoder;
   import mbd_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] vld = 3'b000;
   logic [23:0] addr = '0;
   logic       rd_wr_n = 1'b1;
   logic [7:0] wdata = '0;
   logic [3:0] cs_n [3];
   logic       ack [3];
   logic       err [3];
   logic [7:0] rdata [3];
   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   mem_bank_decoder #(.MODE(DEC_FULL)) i_mem_bank_decoder (
      .clk(clk), .rst_n(rst_n), .req_vld(vld[0]), .req_addr(addr), .rd_wr_n(rd_wr_n),
      .wdata(wdata), .cs_n(cs_n[0]), .ack(ack[0]), .bus_err(err[0]), .rdata(rdata[0]));
   mem_bank_decoder #(.MODE(DEC_PARTIAL)) i_mem_bank_decoder_part (
      .clk(clk), .rst_n(rst_n), .req_vld(vld[1]), .req_addr(addr), .rd_wr_n(rd_wr_n),
      .wdata(wdata), .cs_n(cs_n[1]), .ack(ack[1]), .bus_err(err[1]), .rdata(rdata[1]));
   mem_bank_decoder #(.MODE(DEC_MIXED)) i_mem_bank_decoder_mix (
      .clk(clk), .rst_n(rst_n), .req_vld(vld[2]), .req_addr(addr), .rd_wr_n(rd_wr_n),
      .wdata(wdata), .cs_n(cs_n[2]), .ack(ack[2]), .bus_err(err[2]), .rdata(rdata[2]));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one request on unit u; checks select now, response one cycle later
   task automatic access(int u, logic [23:0] a, bit wr, logic [7:0] d,
                         logic [3:0] exp_cs, bit exp_err, bit chk_rd,
                         logic [7:0] exp_rd, string req);
      @(negedge clk);
      vld[u]  = 1'b1;
      addr    = a;
      rd_wr_n = ~wr;
      wdata   = d;
      #1;
      check({req, " cs_n"}, 32'(cs_n[u]), 32'(exp_cs));
      @(negedge clk);
      vld[u] = 1'b0;
      check({req, " ack"}, 32'(ack[u]), 32'd1);
      check({req, " bus_err"}, 32'(err[u]), 32'(exp_err));
      if (chk_rd) check({req, " rdata"}, 32'(rdata[u]), 32'(exp_rd));
   endtask

   task automatic t_reset();
      for (int u = 0; u < 3; u++) begin
         check("R5 reset cs_n", 32'(cs_n[u]), 32'hF);
         check("R5 reset ack", 32'(ack[u]), 32'd0);
         check("R5 reset bus_err", 32'(err[u]), 32'd0);
      end
   endtask

   task automatic t_full();
      access(0, 24'h000010, 1, 8'hA5, 4'b1110, 0, 0, 8'h00, "R1 full wr bank0");
      access(0, 24'h001010, 1, 8'h5A, 4'b1101, 0, 0, 8'h00, "R1 full wr bank1");
      access(0, 24'h000010, 0, 8'h00, 4'b1110, 0, 1, 8'hA5, "R6 full rd bank0");
      access(0, 24'h001010, 0, 8'h00, 4'b1101, 0, 1, 8'h5A, "R6 full rd bank1");
      access(0, 24'h002010, 1, 8'h77, 4'b1111, 1, 1, 8'h00, "R7 full wr empty");
      access(0, 24'h800010, 0, 8'h00, 4'b1111, 1, 1, 8'h00, "R1 full rd top");
      access(0, 24'h000010, 0, 8'h00, 4'b1110, 0, 1, 8'hA5, "R8 full bank0 intact");
      access(0, 24'h001010, 0, 8'h00, 4'b1101, 0, 1, 8'h5A, "R8 full bank1 intact");
      access(0, 24'hFFF010, 0, 8'h00, 4'b1111, 1, 1, 8'h00, "R9 full no upper bank");
   endtask

   task automatic t_pulse_idle();
      access(0, 24'h000010, 0, 8'h00, 4'b1110, 0, 1, 8'hA5, "R6 pulse rd");
      @(negedge clk);
      check("R6 ack single cycle", 32'(ack[0]), 32'd0);
      addr = 24'h001010;
      #1;
      check("R5 idle cs_n", 32'(cs_n[0]), 32'hF);
      check("R5 idle bus_err", 32'(err[0]), 32'd0);
   endtask

   task automatic t_partial();
      access(1, 24'h000020, 1, 8'h3C, 4'b1110, 0, 0, 8'h00, "R2 part wr low");
      access(1, 24'h7FF020, 0, 8'h00, 4'b1110, 0, 1, 8'h3C, "R2 part alias low");
      access(1, 24'h800030, 1, 8'hC3, 4'b1101, 0, 0, 8'h00, "R2 part wr high");
      access(1, 24'hFFF030, 0, 8'h00, 4'b1101, 0, 1, 8'hC3, "R2 part alias high");
      access(1, 24'h123420, 0, 8'h00, 4'b1110, 0, 1, 8'h3C, "R2 part mid alias");
      access(1, 24'hC00030, 0, 8'h00, 4'b1101, 0, 1, 8'hC3, "R9 part upper idle");
   endtask

   task automatic t_mixed();
      access(2, 24'h000040, 1, 8'h11, 4'b1110, 0, 0, 8'h00, "R3 mix wr bank0");
      access(2, 24'h400040, 1, 8'h22, 4'b1101, 0, 0, 8'h00, "R3 mix wr bank1");
      access(2, 24'h000040, 0, 8'h00, 4'b1110, 0, 1, 8'h11, "R3 mix rd bank0");
      access(2, 24'h400040, 0, 8'h00, 4'b1101, 0, 1, 8'h22, "R3 mix rd bank1");
      access(2, 24'h001040, 1, 8'h99, 4'b1111, 1, 1, 8'h00, "R3 mix a12 empty");
      access(2, 24'h200040, 1, 8'h98, 4'b1111, 1, 1, 8'h00, "R3 mix a21 empty");
      access(2, 24'h401040, 0, 8'h00, 4'b1111, 1, 1, 8'h00, "R7 mix rd empty");
      access(2, 24'h000040, 0, 8'h00, 4'b1110, 0, 1, 8'h11, "R8 mix bank0 intact");
      access(2, 24'h400040, 0, 8'h00, 4'b1101, 0, 1, 8'h22, "R8 mix bank1 intact");
      access(2, 24'h800050, 1, 8'h33, 4'b1011, 0, 0, 8'h00, "R4 mix wr bank2");
      access(2, 24'h801050, 1, 8'h44, 4'b0111, 0, 0, 8'h00, "R4 mix wr bank3");
      access(2, 24'hBFE050, 0, 8'h00, 4'b1011, 0, 1, 8'h33, "R4 mix alias bank2");
      access(2, 24'hC37050, 0, 8'h00, 4'b0111, 0, 1, 8'h44, "R4 mix alias bank3");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_full();
      t_pulse_idle();
      t_partial();
      t_mixed();
      repeat (2) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule